// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block turns word-wide internal read and write requests into cycles on an external asynchronous static memory bus, for devices such as an SRAM or a register window inside an FPGA. A request carries an address, eight byte enables, 64 bits of write data and a size flag that selects a 32-bit or a 64-bit transfer. The block splits the request into bus beats, times each beat with programmable wait counts, and then pulses a ready signal. The external bus may be 32 or 8 bits wide.

The block has five configuration registers. They set the bus width, the page-mode read, the byte-lane strobe behaviour, and the wait counts for first read, page read, write and turnaround. A page-mode read keeps chip select and output enable low across up to four beats of one page. Only the first beat of the page pays the full read wait. A write never uses page mode. After each request the block stays idle for the programmed number of turnaround cycles before it accepts the next one.

Top module: `static_bus_ctrl`

## Requirements
- R1: After synchronous active-high reset, `bus_cs_n`, `bus_oe_n`, `bus_we_n` are 1, `bus_bls_n` is 4'hF, `bus_dout_en` and `rsp_ready` are 0. The configuration comes back as: mode 0, first-read wait 2, page wait 1, write wait 1, turnaround 1.
- R2: A cycle with `cfg_we` high writes `cfg_wdata` to the register chosen by `cfg_sel`. Select 0 is the mode register: bit 0 selects the 8-bit bus, bit 1 enables page-mode reads, bit 2 sets the byte-lane state. Select 1 is the first-read wait, 2 the page wait, 3 the write wait and 4 the turnaround count.
- R3: A beat with wait count N holds its strobes for N+1 cycles. Beats that are not page continuations are separated by one idle cycle with chip select high. `rsp_ready` is seen one cycle after the last strobe cycle.
- R4: On a 32-bit bus, a 32-bit request is one beat at the address with bits 1:0 cleared. A 64-bit request is two beats, at the address with bits 2:0 cleared and at that address plus 4, carrying data bits 31:0 and then 63:32. On an 8-bit bus, each request byte k is one beat at base+k on data bits 7:0, so a request takes 4 or 8 beats.
- R5: A write produces exactly one `bus_dout_en` pulse per beat. Only the lanes whose strobe is low update the device.
- R6: With page mode on, a read beat whose page position is nonzero follows the previous beat with no idle cycle and uses the page wait. The page position is address bits 3:2 on a 32-bit bus and bits 1:0 on an 8-bit bus. A position-0 beat starts a new page with the first-read wait.
- R7: With the lane-state bit clear, all strobes stay high during reads, the strobes of enabled bytes go low during writes, and `bus_we_n` stays high.
- R8: With the lane-state bit set, the strobes of enabled bytes go low on reads and on writes, and `bus_we_n` is low for every write strobe cycle.
- R9: Chip select is low whenever output enable is low or write data is driven. Output enable is low only on reads and `bus_dout_en` is high only on writes.
- R10: `rsp_ready` is high for exactly one cycle per request, and `rsp_rdata` holds the read data in that cycle. On a 32-bit request the upper half reads as zero.
- R11: A request is accepted only when idle. After `rsp_ready`, T turnaround cycles pass, then one idle cycle, then the next held request's first strobe. A request held during an access is accepted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | WAIT_W | Configuration write value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 8 | Byte enables |
| req_wdata | input | 64 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | 32 | External write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 32 | External read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_bls_n | output | 4 | Byte-lane strobes, active low |

## Verification
The bench builds the block with ADDR_W=8 and WAIT_W=3, so a 256-byte device model covers the whole address space and a small set of wait values covers both zero and nonzero counts. The sweep runs every one of the eight mode combinations. It crosses them with two values each of the read, page and write waits and with all four request kinds. The bench computes each expected latency from the beat and page count, and each expected byte from a reference image. The two 8-bit page-mode reads reach the page-break case, where the fifth beat returns to the first-read wait. Back-to-back requests with turnaround 0 and 3 exercise the acceptance spacing.

// File: rtl/static_bus_ctrl.sv
module static_bus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [WAIT_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_be,
  input  logic [63:0]       req_wdata,
  output logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_dout,
  output logic              bus_dout_en,
  input  logic [31:0]       bus_din,
  output logic              bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [3:0]        bus_bls_n
);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP, S_TURN} st_t;

  st_t               state;
  logic [2:0]        mode_r;
  logic [WAIT_W-1:0] w_rd, w_pg, w_wr, w_tn;
  logic              bus8_q, page_q, lane_q, write_q, wide_q;
  logic [ADDR_W-1:0] base_q;
  logic [7:0]        be_q;
  logic [63:0]       wdata_q;
  logic [2:0]        beat;
  logic [WAIT_W-1:0] cnt;
  logic [1:0]        pos_next;
  logic [3:0]        strb;
  logic              last_beat, page_next, acc;

  assign acc       = (state == S_ACC);
  assign bus_addr  = base_q + (bus8_q ? ADDR_W'(beat) : ADDR_W'({beat, 2'b00}));
  assign pos_next  = bus8_q ? bus_addr[1:0] + 2'd1 : bus_addr[3:2] + 2'd1;
  assign last_beat = (beat == (bus8_q ? (wide_q ? 3'd7 : 3'd3) : (wide_q ? 3'd1 : 3'd0)));
  assign page_next = page_q && !write_q && (pos_next != 2'd0);
  assign strb      = bus8_q ? {3'b000, be_q[beat]} : (beat[0] ? be_q[7:4] : be_q[3:0]);

  assign bus_cs_n    = !acc;
  assign bus_oe_n    = !(acc && !write_q);
  assign bus_dout_en = acc && write_q;
  assign bus_we_n    = !(acc && write_q && lane_q);
  assign bus_bls_n   = (acc && (write_q || lane_q)) ? ~strb : 4'hF;
  assign bus_dout    = bus8_q ? {24'h0, wdata_q[{beat, 3'b000} +: 8]}
                              : wdata_q[{beat[0], 5'b00000} +: 32];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= 3'd0;
      w_rd   <= WAIT_W'(2);
      w_pg   <= WAIT_W'(1);
      w_wr   <= WAIT_W'(1);
      w_tn   <= WAIT_W'(1);
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: mode_r <= cfg_wdata[2:0];
        3'd1: w_rd   <= cfg_wdata;
        3'd2: w_pg   <= cfg_wdata;
        3'd3: w_wr   <= cfg_wdata;
        3'd4: w_tn   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
      bus8_q    <= 1'b0;
      page_q    <= 1'b0;
      lane_q    <= 1'b0;
      write_q   <= 1'b0;
      wide_q    <= 1'b0;
      base_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      beat      <= '0;
      cnt       <= '0;
    end else begin
      rsp_ready <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          bus8_q    <= mode_r[0];
          page_q    <= mode_r[1];
          lane_q    <= mode_r[2];
          write_q   <= req_write;
          wide_q    <= req_wide;
          base_q    <= {req_addr[ADDR_W-1:3], req_wide ? 1'b0 : req_addr[2], 2'b00};
          be_q      <= req_be;
          wdata_q   <= req_wdata;
          beat      <= '0;
          cnt       <= req_write ? w_wr : w_rd;
          rsp_rdata <= '0;
          state     <= S_ACC;
        end
        S_ACC: begin
          if (cnt != '0) begin
            cnt <= cnt - WAIT_W'(1);
          end else begin
            if (!write_q) begin
              if (bus8_q) rsp_rdata[{beat, 3'b000} +: 8] <= bus_din[7:0];
              else        rsp_rdata[{beat[0], 5'b00000} +: 32] <= bus_din;
            end
            if (last_beat) begin
              rsp_ready <= 1'b1;
              if (w_tn == '0) state <= S_IDLE;
              else begin
                cnt   <= w_tn - WAIT_W'(1);
                state <= S_TURN;
              end
            end else if (page_next) begin
              beat <= beat + 3'd1;
              cnt  <= w_pg;
            end else begin
              beat  <= beat + 3'd1;
              state <= S_GAP;
            end
          end
        end
        S_GAP: begin
          cnt   <= write_q ? w_wr : w_rd;
          state <= S_ACC;
        end
        S_TURN: begin
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - WAIT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);
  assert_we_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> lane_q);
  assert_read_lanes_high_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n && !lane_q) |-> (bus_bls_n == 4'hF));
  assert_cs_covers_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || bus_dout_en) |-> !bus_cs_n);
  assert_dir_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && bus_dout_en));
  assert_turn_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_TURN) |-> bus_cs_n);
  assert_ready_ends_access_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> $past(!bus_cs_n));

endmodule

// File: tb/static_bus_ctrl_tb.sv
module static_bus_ctrl_tb;
  localparam int AW = 8;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [WW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_be = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_ready;
  logic [63:0]   rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_dout, bus_din;
  logic          bus_dout_en, bus_cs_n, bus_oe_n, bus_we_n;
  logic [3:0]    bus_bls_n;

  logic [7:0] mem  [256];
  logic [7:0] refm [256];
  int checks = 0, errors = 0, cycles = 0;
  int pulses = 0, we_cyc = 0, rd_lane = 0, viol = 0;
  bit de_prev = 1'b0;
  bit bus8, page, lane;
  int wrd, wpg, wwr, wtn;

  always #2 clk = ~clk;

  static_bus_ctrl #(.ADDR_W(AW), .WAIT_W(WW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_bls_n(bus_bls_n));

  assign bus_din = {mem[bus_addr + 8'd3], mem[bus_addr + 8'd2], mem[bus_addr + 8'd1], mem[bus_addr]};

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R10 watchdog expired act=%0d exp=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    end else begin
      if (bus_dout_en)
        for (int j = 0; j < 4; j++)
          if (!bus_bls_n[j]) mem[bus_addr + 8'(j)] = bus_dout[8*j +: 8];
      if (bus_dout_en && !de_prev) pulses++;
      de_prev = bus_dout_en;
      if (!bus_we_n) we_cyc++;
      if (!bus_oe_n && bus_bls_n != 4'hF) rd_lane++;
      if (!bus_oe_n && bus_dout_en) viol++;
      if ((!bus_oe_n || bus_dout_en) && bus_cs_n) viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = WW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int m, input int r, input int p, input int w, input int t);
    cfg(0, m); cfg(1, r); cfg(2, p); cfg(3, w); cfg(4, t);
    bus8 = m[0]; page = m[1]; lane = m[2];
    wrd = r; wpg = p; wwr = w; wtn = t;
  endtask

  function automatic int exp_lat(input bit wr, input bit wide);
    int b;
    b = bus8 ? (wide ? 8 : 4) : (wide ? 2 : 1);
    if (!wr && page) begin
      if (bus8) return (b / 4) * ((wrd + 1) + 3 * (wpg + 1)) + (b / 4 - 1);
      return (wrd + 1) + (b - 1) * (wpg + 1);
    end
    return b * ((wr ? wwr : wrd) + 1) + b - 1;
  endfunction

  task automatic txn(input bit wr, input bit wide, input logic [7:0] addr,
                     input logic [7:0] be, input logic [63:0] wd);
    int b, n, p0, w0, l0, v0, nb;
    logic [7:0]  base;
    logic [63:0] exp, got;
    b    = bus8 ? (wide ? 8 : 4) : (wide ? 2 : 1);
    nb   = wide ? 8 : 4;
    base = wide ? (addr & 8'hF8) : (addr & 8'hFC);
    @(negedge clk);
    p0 = pulses; w0 = we_cyc; l0 = rd_lane; v0 = viol;
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_addr = addr; req_be = be; req_wdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end while (!rsp_ready && n < 300);
    chk(n == exp_lat(wr, wide) + 1, (!wr && page) ? "R6 page latency" : "R3 R2 latency",
        64'(n), 64'(exp_lat(wr, wide) + 1));
    chk(viol == v0, "R9 select/direction", 64'(viol - v0), 64'd0);
    if (wr) begin
      for (int i = 0; i < nb; i++) if (be[i]) refm[base + 8'(i)] = wd[8*i +: 8];
      exp = '0; got = '0;
      for (int i = 0; i < 8; i++) begin
        exp[8*i +: 8] = refm[base + 8'(i)];
        got[8*i +: 8] = mem[base + 8'(i)];
      end
      chk(got == exp, "R4 write data at device", got, exp);
      chk(pulses - p0 == b, "R5 one pulse per beat", 64'(pulses - p0), 64'(b));
      chk(we_cyc - w0 == (lane ? b * (wwr + 1) : 0), lane ? "R8 we_n cycles" : "R7 we_n idle",
          64'(we_cyc - w0), 64'(lane ? b * (wwr + 1) : 0));
    end else begin
      exp = '0;
      for (int i = 0; i < nb; i++) exp[8*i +: 8] = refm[base + 8'(i)];
      chk(rsp_rdata == exp, "R10 R4 read data", rsp_rdata, exp);
      chk(lane ? (rd_lane - l0 > 0) : (rd_lane - l0 == 0), lane ? "R8 read strobes" : "R7 read strobes",
          64'(rd_lane - l0), 64'(lane ? 1 : 0));
    end
    @(negedge clk);
    chk(!rsp_ready, "R10 ready single cycle", 64'(rsp_ready), 64'd0);
    repeat (wtn + 1) @(negedge clk);
  endtask

  initial begin
    int k;
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_cs_n && bus_oe_n && bus_we_n && !bus_dout_en, "R1 reset selects",
        64'({bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en}), 64'hE);
    chk(bus_bls_n == 4'hF && !rsp_ready, "R1 reset strobes", 64'({bus_bls_n, rsp_ready}), 64'h1E);
    bus8 = 0; page = 0; lane = 0; wrd = 2; wpg = 1; wwr = 1; wtn = 1;
    txn(1'b0, 1'b0, 8'h20, 8'h0F, 64'h0);
    txn(1'b1, 1'b1, 8'h40, 8'hFF, 64'h0123456789ABCDEF);
    txn(1'b0, 1'b1, 8'h40, 8'hFF, 64'h0);

    k = 0;
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 3; r += 2)
        for (int p = 0; p < 2; p++)
          for (int w = 0; w < 4; w += 3) begin
            setup(m, r, p, w, 1);
            for (int op = 0; op < 4; op++) begin
              k++;
              txn(op[0], op[1], 8'(k * 37), 8'(k * 29) | 8'h11,
                  {32'(k) * 32'h9E3779B1, ~(32'(k) * 32'h85EBCA6B)});
            end
          end

    for (int t = 0; t < 4; t += 3) begin
      int n, kk, extra;
      setup(0, 1, 0, 1, t);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b0; req_addr = 8'h10; req_be = 8'h0F;
      n = 0;
      do begin @(negedge clk); n++; end while (!rsp_ready && n < 300);
      chk(n == 3, "R11 held request latency", 64'(n), 64'd3);
      kk = 0;
      do begin @(negedge clk); kk++; end while (bus_cs_n && kk < 300);
      chk(kk == t + 1, "R11 turnaround spacing", 64'(kk), 64'(t + 1));
      req_valid = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!rsp_ready && n < 300);
      chk(rsp_ready, "R11 second request completes", 64'(rsp_ready), 64'd1);
      extra = 0;
      repeat (40) begin @(negedge clk); if (!bus_cs_n || rsp_ready) extra++; end
      chk(extra == 0, "R11 no duplicate accept", 64'(extra), 64'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule